// File: doc/BRIEF.md
# Four-Way Dynamic Barrier with One-Bit Broadcast

This block lines up a small group of processing elements (PEs) at a common point in their programs. Each PE drives a wait request, one data bit, a proposed membership mask and a parallel interrupt request. It reads back a GO flag, the broadcast vector of every PE's data bit, and the active membership mask. A PE takes part in a synchronization in four port steps. It raises its wait request and waits for GO. It then drops the request and waits for GO to fall. The second, inverted phase proves that every member has seen the release before anyone moves on.

Membership can change at run time. When the inverted phase completes, the new mask is the intersection of the proposals from the current members. The broadcast bits let the PEs agree on those proposals. When any member's data bit differs from the bit it sent at the previous release, the block waits one extra cycle before GO so the new bit is stable. A single interrupt output can follow either barrier release or any PE's interrupt request, as picked by a writable control bit. It is off after reset.

Top module: `barrier_sync`

## Requirements
- R1: After reset the active mask is all ones, every GO bit is low, the broadcast vector is zero and the interrupt output is low and disabled.
- R2: When every member holds its wait request high and no member's data bit has changed, GO rises on all members one clock edge after the last member arrives.
- R3: While any member's wait request is low during the gathering phase, no GO bit is high.
- R4: A PE outside the active mask never delays GO and always reads its own GO bit as low. Its data bit never causes a settle cycle.
- R5: Once GO is high it stays high until every member has dropped its wait request, and it falls one edge after the last member drops.
- R6: If any member's data bit differs from the bit it last sent at a release, GO rises two edges after the last arrival instead of one. Each PE's last-sent bit is 0 after reset.
- R7: bcastData bit i carries PE i's data bit as sampled on the edge where GO rises, and it holds that value while GO stays high and through the release.
- R8: When the inverted phase completes, the active mask becomes the bitwise AND of the members' proposals (PE i's proposal sits at peMask bits i*NUM_PE and up). Proposals from non-members are ignored.
- R9: With interrupts enabled and the select bit at 0, irqOut is high for exactly the one cycle in which GO rises.
- R10: With interrupts enabled and the select bit at 1, irqOut shows the OR of all peIrqReq bits one edge later. With interrupts disabled, irqOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| peWait | input | NUM_PE | Wait request, one bit per PE |
| peData | input | NUM_PE | Broadcast data bit, one per PE |
| peMask | input | NUM_PE*NUM_PE | Proposed next mask per PE, PE i at bits i*NUM_PE +: NUM_PE |
| peIrqReq | input | NUM_PE | Parallel interrupt request per PE |
| cfgWrEn | input | 1 | Write strobe for the interrupt control bits |
| cfgIrqEn | input | 1 | Interrupt enable value to write |
| cfgIrqSel | input | 1 | Interrupt source to write: 0 release, 1 request |
| peGo | output | NUM_PE | GO flag seen by each PE |
| bcastData | output | NUM_PE | Data bits of all PEs captured at release |
| activeMask | output | NUM_PE | Current barrier membership |
| irqOut | output | 1 | Interrupt request output |

## Verification
The bench builds the block with its default of four PEs. This keeps every membership pattern small enough to state by hand. A single run can shrink the mask to three members by vote. It can then show that the excluded PE neither blocks GO, sees GO, nor forces a settle cycle, and then vote the full group back in. With four PEs, the timing of a partial arrival, a data change that forces the settle cycle, and an anti-barrier held open by one straggler can each be checked against an exact edge count.

// File: rtl/barrier_sync_pkg.sv
package barrier_sync_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // GO rises on this edge: sample data, record last bits
    logic complete;  // anti-barrier done on this edge: load voted mask
  } barStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic allArrived;
    logic allLeft;
    logic anyChanged;
  } barStatus_t;

  typedef enum logic [1:0] {
    ST_GATHER  = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_RELEASE = 2'd2
  } barState_t;

endpackage

// File: rtl/barrier_sync_dp.sv
module barrier_sync_dp
  import barrier_sync_pkg::*;
#(
  parameter int NUM_PE = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PE-1:0]          peWait,
  input  logic [NUM_PE-1:0]          peData,
  input  logic [NUM_PE*NUM_PE-1:0]   peMask,
  input  logic [NUM_PE-1:0]          peIrqReq,
  input  logic                       cfgWrEn,
  input  logic                       cfgIrqEn,
  input  logic                       cfgIrqSel,
  input  barStrobe_t                 strobe,
  output barStatus_t                 status,
  output logic [NUM_PE-1:0]          bcastData,
  output logic [NUM_PE-1:0]          activeMask,
  output logic                       irqOut,
  output logic                       irqEnQ
);

  logic [NUM_PE-1:0] arrived;
  logic [NUM_PE-1:0] leftPhase;
  logic [NUM_PE-1:0] changed;
  logic [NUM_PE-1:0] lastData;
  logic [NUM_PE-1:0] vote [NUM_PE];
  logic [NUM_PE-1:0] nextMask;
  logic              irqSelQ;

  // one slice per PE: membership-qualified arrival, departure, change and vote
  for (genvar p = 0; p < NUM_PE; p++) begin : g_slice
    logic [NUM_PE-1:0] proposal;
    assign proposal     = peMask[p*NUM_PE +: NUM_PE];
    assign arrived[p]   = ~activeMask[p] | peWait[p];
    assign leftPhase[p] = ~activeMask[p] | ~peWait[p];
    assign changed[p]   = activeMask[p] & (peData[p] ^ lastData[p]);
    assign vote[p]      = activeMask[p] ? proposal : {NUM_PE{1'b1}};
  end

  always_comb begin
    nextMask = {NUM_PE{1'b1}};
    for (int p = 0; p < NUM_PE; p++) begin
      nextMask = nextMask & vote[p];
    end
  end

  assign status.allArrived = &arrived;
  assign status.allLeft    = &leftPhase;
  assign status.anyChanged = |changed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMask <= {NUM_PE{1'b1}};
      lastData   <= '0;
      bcastData  <= '0;
    end else begin
      if (strobe.capture) begin
        bcastData <= peData;
        lastData  <= (peData & activeMask) | (lastData & ~activeMask);
      end
      if (strobe.complete) begin
        activeMask <= nextMask;
      end
    end
  end

  // interrupt control and output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ  <= 1'b0;
      irqSelQ <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        irqEnQ  <= cfgIrqEn;
        irqSelQ <= cfgIrqSel;
      end
      irqOut <= irqEnQ & (irqSelQ ? |peIrqReq : strobe.capture);
    end
  end

endmodule

// File: rtl/barrier_sync_ctl.sv
module barrier_sync_ctl
  import barrier_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  barStatus_t status,
  output barStrobe_t strobe,
  output logic       goQ
);

  barState_t state;
  barState_t stateNext;

  always_comb begin
    stateNext      = state;
    strobe.capture  = 1'b0;
    strobe.complete = 1'b0;
    unique case (state)
      ST_GATHER: begin
        if (status.allArrived) begin
          if (status.anyChanged) begin
            stateNext = ST_SETTLE;
          end else begin
            stateNext      = ST_RELEASE;
            strobe.capture = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (status.allArrived) begin
          stateNext      = ST_RELEASE;
          strobe.capture = 1'b1;
        end else begin
          stateNext = ST_GATHER;
        end
      end
      ST_RELEASE: begin
        if (status.allLeft) begin
          stateNext       = ST_GATHER;
          strobe.complete = 1'b1;
        end
      end
      default: stateNext = ST_GATHER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_GATHER;
      goQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture) begin
        goQ <= 1'b1;
      end else if (strobe.complete) begin
        goQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
  import barrier_sync_pkg::*;
#(
  parameter int NUM_PE = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PE-1:0]          peWait,
  input  logic [NUM_PE-1:0]          peData,
  input  logic [NUM_PE*NUM_PE-1:0]   peMask,
  input  logic [NUM_PE-1:0]          peIrqReq,
  input  logic                       cfgWrEn,
  input  logic                       cfgIrqEn,
  input  logic                       cfgIrqSel,
  output logic [NUM_PE-1:0]          peGo,
  output logic [NUM_PE-1:0]          bcastData,
  output logic [NUM_PE-1:0]          activeMask,
  output logic                       irqOut
);

  barStrobe_t strobe;
  barStatus_t status;
  logic       goQ;
  logic       irqEnQ;

  barrier_sync_ctl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe),
    .goQ    (goQ)
  );

  barrier_sync_dp #(.NUM_PE(NUM_PE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .peWait     (peWait),
    .peData     (peData),
    .peMask     (peMask),
    .peIrqReq   (peIrqReq),
    .cfgWrEn    (cfgWrEn),
    .cfgIrqEn   (cfgIrqEn),
    .cfgIrqSel  (cfgIrqSel),
    .strobe     (strobe),
    .status     (status),
    .bcastData  (bcastData),
    .activeMask (activeMask),
    .irqOut     (irqOut),
    .irqEnQ     (irqEnQ)
  );

  assign peGo = {NUM_PE{goQ}} & activeMask;

endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
  parameter int NUM_PE = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_PE-1:0] peWait,
  input logic [NUM_PE-1:0] peGo,
  input logic [NUM_PE-1:0] bcastData,
  input logic [NUM_PE-1:0] activeMask,
  input logic              irqOut,
  input logic              irqEnQ
);

  AST_GO_NEEDS_ALL_MEMBERS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|peGo) |-> (($past(peWait) & activeMask) == activeMask)); // R3

  AST_NON_MEMBER_NO_GO: assert property (@(posedge clk) disable iff (!rstN)
    (peGo & ~activeMask) == '0); // R4

  AST_GO_FALLS_AFTER_ALL_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|peGo) |-> (($past(peWait) & $past(activeMask)) == '0)); // R5

  AST_BCAST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((|peGo) && $past(|peGo)) |-> $stable(bcastData)); // R7

  AST_IRQ_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(irqEnQ) |-> !irqOut); // R10

endmodule

bind barrier_sync barrier_sync_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .peWait     (peWait),
  .peGo       (peGo),
  .bcastData  (bcastData),
  .activeMask (activeMask),
  .irqOut     (irqOut),
  .irqEnQ     (irqEnQ)
);

// File: tb/barrier_sync_tb.sv
module barrier_sync_tb;

  localparam int NUM_PE = 4;
  localparam int SEL_GO = 0, SEL_BC = 1, SEL_MASK = 2, SEL_IRQ = 3;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic [NUM_PE-1:0]        peWait = '0;
  logic [NUM_PE-1:0]        peData = '0;
  logic [NUM_PE*NUM_PE-1:0] peMask = '1;
  logic [NUM_PE-1:0]        peIrqReq = '0;
  logic                     cfgWrEn = 1'b0;
  logic                     cfgIrqEn = 1'b0;
  logic                     cfgIrqSel = 1'b0;
  logic [NUM_PE-1:0]        peGo;
  logic [NUM_PE-1:0]        bcastData;
  logic [NUM_PE-1:0]        activeMask;
  logic                     irqOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    int          at;
    string       req;
    int          sel;
    logic [31:0] exp;
  } expItem_t;

  expItem_t sbq[$];

  barrier_sync #(.NUM_PE(NUM_PE)) u_dut (
    .clk(clk), .rstN(rstN), .peWait(peWait), .peData(peData), .peMask(peMask),
    .peIrqReq(peIrqReq), .cfgWrEn(cfgWrEn), .cfgIrqEn(cfgIrqEn), .cfgIrqSel(cfgIrqSel),
    .peGo(peGo), .bcastData(bcastData), .activeMask(activeMask), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  // driver side: queue an expected value for the sample after dly more edges
  task automatic expectAt(int dly, string req, int sel, logic [31:0] val);
    expItem_t it;
    it.at = cyc + dly; it.req = req; it.sel = sel; it.exp = val;
    sbq.push_back(it);
  endtask

  task automatic setProposals(logic [NUM_PE-1:0] p0, logic [NUM_PE-1:0] p1,
                              logic [NUM_PE-1:0] p2, logic [NUM_PE-1:0] p3);
    peMask = {p3, p2, p1, p0};
  endtask

  task automatic writeCfg(logic en, logic sel);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIrqEn = en; cfgIrqSel = sel;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // monitor side: sample away from the edge and compare due items
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].at == cyc) begin
          logic [31:0] act;
          case (sbq[i].sel)
            SEL_GO:   act = 32'(peGo);
            SEL_BC:   act = 32'(bcastData);
            SEL_MASK: act = 32'(activeMask);
            default:  act = 32'(irqOut);
          endcase
          nChecks++;
          if (act !== sbq[i].exp) begin
            nFails++;
            $display("FAIL %s cycle %0d sel %0d actual %0h expected %0h",
                     sbq[i].req, cyc, sbq[i].sel, act, sbq[i].exp);
          end
          sbq.delete(i);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectAt(1, "R1", SEL_GO, 0);
    expectAt(1, "R1", SEL_MASK, 4'hF);
    expectAt(1, "R1", SEL_IRQ, 0);
    expectAt(1, "R1", SEL_BC, 0);

    // Test A: release interrupt, unchanged data (last bits zero after reset)
    writeCfg(1'b1, 1'b0);
    @(negedge clk);
    peWait = 4'hF; peData = 4'h0;
    expectAt(1, "R2", SEL_GO, 4'hF);       // one edge after arrival
    expectAt(1, "R9", SEL_IRQ, 1);
    expectAt(2, "R9", SEL_IRQ, 0);         // single-cycle pulse
    @(negedge clk);
    peWait = 4'h0;
    expectAt(1, "R5", SEL_GO, 0);
    expectAt(1, "R8", SEL_MASK, 4'hF);

    // Test B: partial arrival, data change -> settle cycle, broadcast hold
    @(negedge clk);
    peWait = 4'b0111; peData = 4'b1010;
    expectAt(1, "R3", SEL_GO, 0);
    expectAt(2, "R3", SEL_GO, 0);
    @(negedge clk);
    @(negedge clk);
    peWait = 4'hF;
    expectAt(1, "R6", SEL_GO, 0);          // settle cycle
    expectAt(2, "R6", SEL_GO, 4'hF);
    expectAt(2, "R7", SEL_BC, 4'b1010);
    @(negedge clk);
    @(negedge clk);
    peWait = 4'b1000; peData = 4'b0101;    // one straggler still waiting
    expectAt(1, "R5", SEL_GO, 4'hF);
    expectAt(1, "R7", SEL_BC, 4'b1010);
    @(negedge clk);
    peWait = 4'h0;
    setProposals(4'b0111, 4'b0111, 4'b1111, 4'b0111);
    expectAt(1, "R5", SEL_GO, 0);
    expectAt(1, "R8", SEL_MASK, 4'b0111);
    expectAt(1, "R7", SEL_BC, 4'b1010);

    // Test C: PE3 excluded; its wait, data and proposal have no effect
    @(negedge clk);
    peWait = 4'b0111; peData = 4'b0010;    // PE3 bit flipped, members unchanged
    setProposals(4'b0111, 4'b0111, 4'b0111, 4'b0000);
    expectAt(1, "R4", SEL_GO, 4'b0111);
    expectAt(1, "R7", SEL_BC, 4'b0010);
    @(negedge clk);
    peWait = 4'b1000;
    expectAt(1, "R4", SEL_GO, 0);
    expectAt(1, "R8", SEL_MASK, 4'b0111);

    // Test D: request-driven interrupt, then disable
    writeCfg(1'b1, 1'b1);
    peWait = 4'h0;
    @(negedge clk);
    peIrqReq = 4'b0100;
    expectAt(1, "R10", SEL_IRQ, 1);
    @(negedge clk);
    peIrqReq = 4'b0000;
    expectAt(1, "R10", SEL_IRQ, 0);
    writeCfg(1'b0, 1'b0);
    peIrqReq = 4'hF;
    expectAt(1, "R10", SEL_IRQ, 0);
    @(negedge clk);
    peIrqReq = 4'h0;
    peWait = 4'b0111; peData = 4'b1010;
    expectAt(1, "R2", SEL_GO, 4'b0111);
    expectAt(1, "R9", SEL_IRQ, 0);         // disabled: no release pulse
    @(negedge clk);
    peWait = 4'h0;
    setProposals(4'hF, 4'hF, 4'hF, 4'h0);
    expectAt(1, "R8", SEL_MASK, 4'hF);
    expectAt(1, "R5", SEL_GO, 0);

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard actual %0d pending expected 0", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule